// File: doc/BRIEF.md
# Interrupt Entry Flag Sequencer

This block performs the context save and status-flag rewrite that a 16-bit processor core carries out when it takes an interrupt. The core presents an accept strobe together with the class of the interrupt, its vector number, the priority level of the request, and its current flag word, program counter and both stack pointers. The block chooses a stack and pushes the old flag word and then the program counter through a one-word-per-cycle write port. It then returns the rewritten flag word and both stack pointers, with a one-cycle done strobe.

The rewritten flag word depends on the class. The stack-select bit is cleared unless the request is a software vector in the upper half (32 to 63). Those upper vectors push onto whichever stack the select bit already names and leave that bit alone. The interrupt-enable and debug bits are always cleared. The three-bit priority field is loaded from the request, forced to 7, forced to 0 or kept, according to the class.

The block also holds the non-maskable interrupt front end. An active-low pin is synchronised and watched for a falling edge. The edge is held as a pending request until an entry of the non-maskable class is taken. The synchronised pin level is available as a status output.

Top module: `irq_entry_seq`

## Requirements
- R1: The cycle after an accepted strobe, the port writes the original flag word to address SP-2 with the write enable high. The next cycle it writes the program counter to SP-4. The write enable is high in exactly those two cycles. SP is the stack pointer chosen by R2.
- R2: Class codes are 0 reset, 1 maskable, 2 non-maskable, 3 watchdog, 4 debug/single-step/address-match, 5 break/overflow/undefined and 6 software (7 behaves as 5). For class 6 with vector 32 to 63, the user stack is used when flag bit 7 (stack select) is 1, and the interrupt stack is used otherwise. All other requests use the interrupt stack.
- R3: The cycle after the second write, done is high for exactly one cycle. In that cycle flg_out, isp_out and usp_out hold the result. The stack pointer used is reduced by 4, and the other is passed through unchanged.
- R4: In flg_out the interrupt-enable bit (bit 6) and the debug bit (bit 5) are 0 after every entry.
- R5: Flag bit 7 is cleared in flg_out for every request except class 6 with vector 32 to 63, which keeps it.
- R6: For class 1 the priority field (bits 14:12) is loaded with req_level.
- R7: Class 0 sets the priority field to 0. Classes 2 and 3 set it to 7.
- R8: Classes 4 to 7 leave the priority field unchanged. All flag bits other than 14:12, 7, 6 and 5 pass through unchanged for every class.
- R9: busy is high during the two write cycles. An accept strobe that arrives while busy is high is ignored: it causes no extra write and no extra done pulse.
- R10: A high-to-low transition on nmi_n sets nmi_pending three clock edges later. A low-to-high transition does not set it. nmi_level shows the pin level two edges after it changes.
- R11: nmi_pending is cleared at the edge where a class 2 request is accepted. Entries of other classes leave it set.
- R12: After reset, stk_we, done, busy and nmi_pending are 0, nmi_level is 1, and flg_out, isp_out and usp_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept | input | 1 | Interrupt accepted by the core |
| irq_class | input | 3 | Interrupt class code |
| irq_vec | input | 6 | Vector number |
| req_level | input | 3 | Priority level of the request |
| flg_in | input | 16 | Current flag word |
| pc_in | input | 16 | Current program counter |
| isp_in | input | 16 | Current interrupt stack pointer |
| usp_in | input | 16 | Current user stack pointer |
| nmi_n | input | 1 | Non-maskable interrupt pin, active low |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 16 | Stack write data |
| stk_we | output | 1 | Stack write enable |
| busy | output | 1 | Save sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| flg_out | output | 16 | Rewritten flag word |
| isp_out | output | 16 | Updated interrupt stack pointer |
| usp_out | output | 16 | Updated user stack pointer |
| nmi_pending | output | 1 | Latched non-maskable request |
| nmi_level | output | 1 | Synchronised pin level |

## Verification
The assertions check the shape of the sequence on every cycle. They confirm that a write burst is two words long and that the addresses step down by 2. They confirm that done is a single pulse directly after the two writes, and that the enable and debug bits are clear whenever done is high. A pending request may appear only after a low level has been seen. The class-dependent parts need the inputs that the bench drove: the stack choice, the priority field, the stack-select bit and the pointer arithmetic. The bench shows these by sweeping every class, the vector boundaries 31/32 and both stack-select values. It also shows that an accept during a busy sequence is ignored and that the non-maskable pending flag is handed over correctly.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    IC_RESET    = 3'd0,
    IC_MASKABLE = 3'd1,
    IC_NMI      = 3'd2,
    IC_WDOG     = 3'd3,
    IC_DEBUG    = 3'd4,
    IC_TRAP     = 3'd5,
    IC_SOFT     = 3'd6,
    IC_SPARE    = 3'd7
  } irq_class_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_PC    = 2'd1,
    PS_DONE  = 2'd2
  } push_state_e;
endpackage

// File: rtl/nmi_front.sv
module nmi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic ack,
  output logic pending,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall  = last_q & ~sync_q[SYNC_STAGES-1];
  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)       pending <= 1'b0;
    else if (fall) pending <= 1'b1;
    else if (ack)  pending <= 1'b0;
  end
endmodule

// File: rtl/flag_rewrite.sv
module flag_rewrite
  import irq_entry_pkg::*;
#(
  parameter int W        = 16,
  parameter int VEC_W    = 6,
  parameter int IPL_LSB  = 12,
  parameter int IPL_W    = 3,
  parameter int SSEL_BIT = 7,
  parameter int IEN_BIT  = 6,
  parameter int DBG_BIT  = 5,
  parameter int SOFT_SPLIT = 32
) (
  input  irq_class_e       cls,
  input  logic [VEC_W-1:0] vec,
  input  logic [IPL_W-1:0] lvl,
  input  logic [W-1:0]     flg,
  output logic [W-1:0]     flg_new,
  output logic             use_user
);
  localparam logic [IPL_W-1:0] IPL_TOP = '1;
  logic keep_sel;

  assign keep_sel = (cls == IC_SOFT) && (vec >= VEC_W'(SOFT_SPLIT));
  assign use_user = keep_sel & flg[SSEL_BIT];

  always_comb begin
    flg_new = flg;
    if (!keep_sel) flg_new[SSEL_BIT] = 1'b0;
    flg_new[IEN_BIT] = 1'b0;
    flg_new[DBG_BIT] = 1'b0;
    unique case (cls)
      IC_RESET:         flg_new[IPL_LSB +: IPL_W] = '0;
      IC_MASKABLE:      flg_new[IPL_LSB +: IPL_W] = lvl;
      IC_NMI, IC_WDOG:  flg_new[IPL_LSB +: IPL_W] = IPL_TOP;
      default:          flg_new[IPL_LSB +: IPL_W] = flg[IPL_LSB +: IPL_W];
    endcase
  end
endmodule

// File: rtl/push_seq.sv
module push_seq
  import irq_entry_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          use_user,
  input  logic [W-1:0]  flg_old,
  input  logic [W-1:0]  flg_new,
  input  logic [W-1:0]  pc,
  input  logic [AW-1:0] isp,
  input  logic [AW-1:0] usp,
  output logic [AW-1:0] stk_addr,
  output logic [W-1:0]  stk_wdata,
  output logic          stk_we,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  flg_out,
  output logic [AW-1:0] isp_out,
  output logic [AW-1:0] usp_out
);
  localparam logic [AW-1:0] STEP  = AW'(WORD_BYTES);
  localparam logic [AW-1:0] FRAME = AW'(2 * WORD_BYTES);

  push_state_e   state;
  logic [W-1:0]  pc_q, flg_q;
  logic [AW-1:0] isp_q, usp_q;
  logic          user_q;
  logic [AW-1:0] sp_sel;

  assign sp_sel = use_user ? usp : isp;
  assign busy   = (state != PS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_IDLE;
      stk_addr  <= '0;
      stk_wdata <= '0;
      stk_we    <= 1'b0;
      done      <= 1'b0;
      flg_out   <= '0;
      isp_out   <= '0;
      usp_out   <= '0;
      pc_q      <= '0;
      flg_q     <= '0;
      isp_q     <= '0;
      usp_q     <= '0;
      user_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        PS_IDLE: begin
          if (start) begin
            stk_we    <= 1'b1;
            stk_addr  <= sp_sel - STEP;
            stk_wdata <= flg_old;
            pc_q      <= pc;
            flg_q     <= flg_new;
            isp_q     <= isp;
            usp_q     <= usp;
            user_q    <= use_user;
            state     <= PS_PC;
          end
        end
        PS_PC: begin
          stk_addr  <= stk_addr - STEP;
          stk_wdata <= pc_q;
          state     <= PS_DONE;
        end
        PS_DONE: begin
          stk_we  <= 1'b0;
          done    <= 1'b1;
          flg_out <= flg_q;
          isp_out <= user_q ? isp_q : isp_q - FRAME;
          usp_out <= user_q ? usp_q - FRAME : usp_q;
          state   <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int W        = 16,
  parameter int AW       = 16,
  parameter int VEC_W    = 6,
  parameter int IPL_LSB  = 12,
  parameter int SSEL_BIT = 7,
  parameter int IEN_BIT  = 6,
  parameter int DBG_BIT  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [2:0]       irq_class,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [2:0]       req_level,
  input  logic [W-1:0]     flg_in,
  input  logic [W-1:0]     pc_in,
  input  logic [AW-1:0]    isp_in,
  input  logic [AW-1:0]    usp_in,
  input  logic             nmi_n,
  output logic [AW-1:0]    stk_addr,
  output logic [W-1:0]     stk_wdata,
  output logic             stk_we,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     flg_out,
  output logic [AW-1:0]    isp_out,
  output logic [AW-1:0]    usp_out,
  output logic             nmi_pending,
  output logic             nmi_level
);
  irq_class_e cls;
  logic       start;
  logic       use_user;
  logic [W-1:0] flg_new;

  assign cls   = irq_class_e'(irq_class);
  assign start = accept & ~busy;

  nmi_front #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst(rst), .pin_n(nmi_n),
    .ack(start && (cls == IC_NMI)),
    .pending(nmi_pending), .level(nmi_level)
  );

  flag_rewrite #(
    .W(W), .VEC_W(VEC_W), .IPL_LSB(IPL_LSB), .IPL_W(3),
    .SSEL_BIT(SSEL_BIT), .IEN_BIT(IEN_BIT), .DBG_BIT(DBG_BIT),
    .SOFT_SPLIT(32)
  ) u_flags (
    .cls(cls), .vec(irq_vec), .lvl(req_level), .flg(flg_in),
    .flg_new(flg_new), .use_user(use_user)
  );

  push_seq #(.W(W), .AW(AW), .WORD_BYTES(2)) u_push (
    .clk(clk), .rst(rst), .start(start), .use_user(use_user),
    .flg_old(flg_in), .flg_new(flg_new), .pc(pc_in),
    .isp(isp_in), .usp(usp_in),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_we(stk_we),
    .busy(busy), .done(done), .flg_out(flg_out),
    .isp_out(isp_out), .usp_out(usp_out)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int W       = 16,
  parameter int AW      = 16,
  parameter int IEN_BIT = 6,
  parameter int DBG_BIT = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] stk_addr,
  input logic          stk_we,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  flg_out,
  input logic          nmi_pending,
  input logic          nmi_level
);
  localparam logic [AW-1:0] STRIDE = AW'(2);

  p_burst_two_r1: assert property (@(posedge clk) disable iff (rst)
    (stk_we && !$past(stk_we)) |=> stk_we);

  p_addr_stride_r1: assert property (@(posedge clk) disable iff (rst)
    (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - STRIDE));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_follows_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(stk_we) && $past(stk_we, 2) && !stk_we));

  p_bits_clear_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!flg_out[IEN_BIT] && !flg_out[DBG_BIT]));

  p_busy_write_r9: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> busy);

  p_nmi_edge_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_pending) |-> !$past(nmi_level));
endmodule

bind irq_entry_seq irq_entry_chk #(
  .W(W), .AW(AW), .IEN_BIT(IEN_BIT), .DBG_BIT(DBG_BIT)
) i_chk (
  .clk(clk), .rst(rst), .stk_addr(stk_addr), .stk_we(stk_we),
  .busy(busy), .done(done), .flg_out(flg_out),
  .nmi_pending(nmi_pending), .nmi_level(nmi_level)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        accept = 1'b0;
  logic [2:0]  irq_class = '0;
  logic [5:0]  irq_vec = '0;
  logic [2:0]  req_level = '0;
  logic [15:0] flg_in = '0, pc_in = '0, isp_in = '0, usp_in = '0;
  logic        nmi_n = 1'b1;
  logic [15:0] stk_addr, stk_wdata, flg_out, isp_out, usp_out;
  logic        stk_we, busy, done, nmi_pending, nmi_level;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst(rst), .accept(accept), .irq_class(irq_class),
    .irq_vec(irq_vec), .req_level(req_level), .flg_in(flg_in),
    .pc_in(pc_in), .isp_in(isp_in), .usp_in(usp_in), .nmi_n(nmi_n),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_we(stk_we),
    .busy(busy), .done(done), .flg_out(flg_out), .isp_out(isp_out),
    .usp_out(usp_out), .nmi_pending(nmi_pending), .nmi_level(nmi_level)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_flags(input int c, input int v, input logic [2:0] l, input logic [15:0] f);
    logic [15:0] e = f;
    bit hi_soft = (c == 6) && (v >= 32);
    if (!hi_soft) e[7] = 1'b0;
    e[6] = 1'b0;
    e[5] = 1'b0;
    if (c == 0) e[14:12] = 3'd0;
    else if (c == 1) e[14:12] = l;
    else if (c == 2 || c == 3) e[14:12] = 3'd7;
    return e;
  endfunction

  task automatic run_entry(input int c, input int v, input logic [2:0] l, input logic [15:0] f,
                           input logic [15:0] pc, input logic [15:0] isp, input logic [15:0] usp,
                           input bit poke_busy);
    bit user = (c == 6) && (v >= 32) && f[7];
    logic [15:0] sp = user ? usp : isp;
    logic [15:0] ef = exp_flags(c, v, l, f);
    irq_class = 3'(c); irq_vec = 6'(v); req_level = l;
    flg_in = f; pc_in = pc; isp_in = isp; usp_in = usp; accept = 1'b1;
    @(posedge clk); @(negedge clk);
    accept = 1'b0;
    chk(stk_we === 1'b1, "R1 we1", 32'(stk_we), 1);
    chk(stk_addr === sp - 16'd2, "R1/R2 addr1", 32'(stk_addr), 32'(sp - 16'd2));
    chk(stk_wdata === f, "R1 data1", 32'(stk_wdata), 32'(f));
    chk(busy === 1'b1, "R9 busy1", 32'(busy), 1);
    if (poke_busy) begin
      accept = 1'b1; irq_class = 3'd2; pc_in = 16'hDEAD; isp_in = 16'h0100;
    end
    @(posedge clk); @(negedge clk);
    chk(stk_we === 1'b1, "R1 we2", 32'(stk_we), 1);
    chk(stk_addr === sp - 16'd4, "R1 addr2", 32'(stk_addr), 32'(sp - 16'd4));
    chk(stk_wdata === pc, "R1 data2", 32'(stk_wdata), 32'(pc));
    @(posedge clk); @(negedge clk);
    accept = 1'b0;
    chk(done === 1'b1, "R3 done", 32'(done), 1);
    chk(stk_we === 1'b0, "R1 we_off", 32'(stk_we), 0);
    chk(flg_out === ef, "R4-flags R5 R6 R7 R8", 32'(flg_out), 32'(ef));
    chk(isp_out === (user ? isp : isp - 16'd4), "R3 isp", 32'(isp_out), 32'(user ? isp : isp - 16'd4));
    chk(usp_out === (user ? usp - 16'd4 : usp), "R3 usp", 32'(usp_out), 32'(user ? usp - 16'd4 : usp));
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R3 done_once", 32'(done), 0);
    if (poke_busy) begin
      chk(stk_we === 1'b0, "R9 no_extra_write", 32'(stk_we), 0);
      @(posedge clk); @(negedge clk);
      chk(done === 1'b0 && stk_we === 1'b0, "R9 no_extra_done", 32'(done), 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int vecs[4] = '{0, 31, 32, 63};
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R12 reset state
    chk(stk_we === 0 && done === 0 && busy === 0, "R12 ctrl", {29'd0, stk_we, done, busy}, 0);
    chk(nmi_pending === 0 && nmi_level === 1, "R12 nmi", {30'd0, nmi_pending, nmi_level}, 1);
    chk(flg_out === 0 && isp_out === 0 && usp_out === 0, "R12 regs", 32'(flg_out), 0);

    // Sweep of classes, vector boundaries, stack select (R2 R5 R6 R7 R8)
    for (int c = 0; c < 8; c++)
      for (int vi = 0; vi < 4; vi++)
        for (int u = 0; u < 2; u++) begin
          logic [15:0] f = 16'hA5FF ^ 16'(c << 9) ^ 16'(vi << 2);
          f[7] = u[0];
          f[14:12] = 3'(c + vi);
          run_entry(c, vecs[vi], 3'(vi * 3 + u + c), f, 16'h1000 + 16'(n),
                    16'h8000 + 16'(n * 8), 16'h4000 + 16'(n * 6), 1'b0);
          n++;
        end

    // R9 accept while busy ignored
    run_entry(1, 5, 3'd4, 16'h00E0, 16'h2222, 16'h9000, 16'h5000, 1'b1);

    // R10 rising edge does not set pending; falling edge does
    nmi_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // after reset the low entry produced a fall; clear it via a class 2 entry
    chk(nmi_pending === 1'b1, "R10 fall_sets", 32'(nmi_pending), 1);
    run_entry(2, 2, 3'd1, 16'h0060, 16'h3000, 16'hA000, 16'h6000, 1'b0);
    chk(nmi_pending === 1'b0, "R11 ack_clears", 32'(nmi_pending), 0);
    nmi_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(nmi_level === 1'b1, "R10 level_high", 32'(nmi_level), 1);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(nmi_pending === 1'b0, "R10 rise_ignored", 32'(nmi_pending), 0);
    nmi_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(nmi_level === 1'b0, "R10 level_low", 32'(nmi_level), 0);
    chk(nmi_pending === 1'b0, "R10 not_yet", 32'(nmi_pending), 0);
    @(posedge clk); @(negedge clk);
    chk(nmi_pending === 1'b1, "R10 third_edge", 32'(nmi_pending), 1);
    // R11 other class keeps pending
    run_entry(3, 0, 3'd0, 16'h7FFF, 16'h4444, 16'hB000, 16'h7000, 1'b0);
    chk(nmi_pending === 1'b1, "R11 other_keeps", 32'(nmi_pending), 1);
    run_entry(2, 0, 3'd0, 16'h1234, 16'h5555, 16'hC000, 16'h7100, 1'b0);
    chk(nmi_pending === 1'b0, "R11 nmi_clears", 32'(nmi_pending), 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule